// File: doc/BRIEF.md
# Piece-wise Sampling Switch Sequencer

This block generates the switch enables for a switched-capacitor front end that reads a resistive bridge. A bank of sampling capacitors has a far (input) side and an integrator side. The far side can connect to one tap of a resistive divider across the bridge supply, to the bridge output, or to ground. The integrator side can connect to the integrator input or to a quiet ground. An external comparator raises `cmp_trip` when the integrator output reaches its threshold, and each such event starts the next logic state.

The sequence repeats three phases without stopping. The signal phase puts all capacitors in parallel on the bridge output. The reference phase measures the large supply in small pieces. Each capacitor in turn is first precharged on the top tap, then moved down the divider one tap per step, and only then does the next capacitor take over. The offset phase grounds the far side and runs half as many steps. Each step opens the integrator side first, then re-routes the far side, then closes the integrator side. A fixed dead window separates these changes, so that charge injection does not depend on the measured voltage. At each step start the block also flips the bridge excitation polarity when the current phase calls for it, and pulses an offset-charge injection.

Top module: `pw_switch_seq`

## Requirements
- R1: During reset and until the first step completes, `phase_tag` is 0, every `cap_en` bit is 1, `brg_en` is 1, `intg_en`, `rgnd_en` and `exc_pol` are 0. Exactly DEAD clock edges after reset release, `intg_en` rises together with an `ofs_inj` pulse.
- R2: A step ends only on a cycle in which `cmp_trip` is high while the integrator side is closed (`intg_en` or `rgnd_en` high). `cmp_trip` while the integrator side is open has no effect on any output.
- R3: After a trip, the integrator side opens on the next cycle. The far-side enables hold for DEAD cycles, then take the next step's value. The integrator side closes DEAD cycles after that. `intg_en` and `rgnd_en` are never high together.
- R4: The signal phase (`phase_tag` = 0) lasts NCAP*NODES steps, with all `cap_en` bits high, `brg_en` high, no tap, and `intg_en` as the closing switch.
- R5: The reference phase (`phase_tag` = 1) lasts NCAP*NODES steps. Step k enables only `cap_en[k / NODES]` and `tap_en[k % NODES]`. Tap 0 (the top node) closes `rgnd_en`, and every other tap closes `intg_en`.
- R6: The offset phase (`phase_tag` = 2) lasts NCAP*NODES/2 steps, with all `cap_en` bits high, `gnd_en` high, no tap and no bridge. It is followed by the signal phase.
- R7: `exc_pol` inverts when a signal-phase step begins. It inverts when a reference-phase step whose index is a multiple of EXC_DIV begins. It holds during the offset phase, and changes only while the integrator side is open.
- R8: `ofs_inj` is high for exactly the first cycle of every step in which the integrator side is closed.
- R9: At most one far-side source (`brg_en`, `gnd_en`, any `tap_en`) is enabled at a time, and at most one `tap_en` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_trip | input | 1 | Comparator threshold event from the integrator |
| cap_en | output | NCAP | Per-capacitor far-side switch enable |
| tap_en | output | NODES | Divider tap select, bit 0 is the top node |
| brg_en | output | 1 | Far side to the bridge output |
| gnd_en | output | 1 | Far side to ground (offset phase) |
| intg_en | output | 1 | Integrator side to the integrator input |
| rgnd_en | output | 1 | Integrator side to ground (precharge) |
| ofs_inj | output | 1 | Offset-charge injection pulse at step start |
| exc_pol | output | 1 | Bridge excitation polarity |
| phase_tag | output | 2 | 0 signal, 1 reference, 2 offset |

## Verification
The comparator input is driven in three ways: held high, sparse single-cycle pulses, and a pseudo-random bit stream. Holding it high runs every step at its shortest length. This exposes a dead window that is too short or a trip accepted while the integrator side is still open. Sparse pulses leave long closed intervals, which separate a stray advance from a legitimate one. The random stream places trips inside the break and make windows, where they must be ignored. Each run wraps through all three phases more than once, so the capacitor-by-tap order, the phase lengths, the offset-phase halving and the excitation flip rate are all compared against the bench's own schedule.

// File: rtl/sps_pkg.sv
`timescale 1ns/1ps
package sps_pkg;

  typedef enum logic [1:0] {
    PH_SIG = 2'd0,
    PH_REF = 2'd1,
    PH_OFS = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    ST_FAR = 2'd0,   // integrator side open, far side on new step
    ST_RUN = 2'd1,   // integrator side closed, waiting for a trip
    ST_BRK = 2'd2    // integrator side open, far side still on old step
  } stage_e;

  // Phase order: signal -> reference -> offset -> signal
  function automatic phase_e phase_after(input phase_e p);
    case (p)
      PH_SIG:  return PH_REF;
      PH_REF:  return PH_OFS;
      default: return PH_SIG;
    endcase
  endfunction

  // Number of comparator steps that make up one phase
  function automatic int unsigned steps_in_phase(input phase_e p,
                                                 input int unsigned ncap,
                                                 input int unsigned nodes);
    int unsigned full;
    full = ncap * nodes;
    case (p)
      PH_SIG:  return full;
      PH_REF:  return full;
      default: return (full / 2 > 0) ? full / 2 : 1;
    endcase
  endfunction

  // Whether the excitation inverts when step idx of phase p begins
  function automatic logic exc_flips(input phase_e p,
                                     input int unsigned idx,
                                     input int unsigned div);
    case (p)
      PH_SIG:  return 1'b1;
      PH_REF:  return (idx % div) == 0;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sps_stage_timer.sv
`timescale 1ns/1ps
module sps_stage_timer
  import sps_pkg::*;
#(
  parameter int unsigned DEAD = 2,
  localparam int unsigned DLY_W = $clog2(DEAD + 1)
)(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   trip,
  output stage_e stage,
  output logic   advance,
  output logic   inj
);

  logic [DLY_W-1:0] dly_q;
  logic             dly_last;

  assign dly_last = (dly_q == DLY_W'(DEAD - 1));
  // position moves on the last cycle of the break window
  assign advance  = (stage == ST_BRK) && dly_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= ST_FAR;
      dly_q <= '0;
      inj   <= 1'b0;
    end else begin
      inj <= 1'b0;
      case (stage)
        ST_FAR: begin
          if (dly_last) begin
            stage <= ST_RUN;
            dly_q <= '0;
            inj   <= 1'b1;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (trip) begin
            stage <= ST_BRK;
            dly_q <= '0;
          end
        end
        ST_BRK: begin
          if (dly_last) begin
            stage <= ST_FAR;
            dly_q <= '0;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        default: begin
          stage <= ST_FAR;
          dly_q <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/sps_position.sv
`timescale 1ns/1ps
module sps_position
  import sps_pkg::*;
#(
  parameter int unsigned NCAP    = 8,
  parameter int unsigned NODES   = 5,
  parameter int unsigned EXC_DIV = 4,
  localparam int unsigned TOTAL  = NCAP * NODES,
  localparam int unsigned STEP_W = $clog2(TOTAL),
  localparam int unsigned CAP_W  = $clog2(NCAP),
  localparam int unsigned NODE_W = $clog2(NODES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output phase_e            phase_q,
  output logic [CAP_W-1:0]  cap_q,
  output logic [NODE_W-1:0] node_q,
  output logic              exc_q
);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] last_idx;
  phase_e            n_phase;
  logic [STEP_W-1:0] n_step;
  logic [CAP_W-1:0]  n_cap;
  logic [NODE_W-1:0] n_node;
  logic              flip;

  assign last_idx = STEP_W'(steps_in_phase(phase_q, NCAP, NODES) - 1);

  always_comb begin
    if (step_q == last_idx) begin
      n_phase = phase_after(phase_q);
      n_step  = '0;
      n_cap   = '0;
      n_node  = '0;
    end else begin
      n_phase = phase_q;
      n_step  = step_q + 1'b1;
      n_cap   = cap_q;
      n_node  = node_q;
      if (phase_q == PH_REF) begin
        // walk down the divider, then hand over to the next capacitor
        if (node_q == NODE_W'(NODES - 1)) begin
          n_node = '0;
          n_cap  = cap_q + 1'b1;
        end else begin
          n_node = node_q + 1'b1;
        end
      end
    end
    flip = exc_flips(n_phase, 32'(n_step), EXC_DIV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SIG;
      step_q  <= '0;
      cap_q   <= '0;
      node_q  <= '0;
      exc_q   <= 1'b0;
    end else if (advance) begin
      phase_q <= n_phase;
      step_q  <= n_step;
      cap_q   <= n_cap;
      node_q  <= n_node;
      exc_q   <= exc_q ^ flip;
    end
  end

endmodule

// File: rtl/sps_switch_map.sv
`timescale 1ns/1ps
module sps_switch_map
  import sps_pkg::*;
#(
  parameter int unsigned NCAP  = 8,
  parameter int unsigned NODES = 5,
  localparam int unsigned CAP_W  = $clog2(NCAP),
  localparam int unsigned NODE_W = $clog2(NODES)
)(
  input  phase_e            phase,
  input  logic [CAP_W-1:0]  cap_idx,
  input  logic [NODE_W-1:0] node_idx,
  input  stage_e            stage,
  output logic [NCAP-1:0]   cap_en,
  output logic [NODES-1:0]  tap_en,
  output logic              brg_en,
  output logic              gnd_en,
  output logic              intg_en,
  output logic              rgnd_en
);

  logic in_ref;
  logic closed;
  logic precharge;

  assign in_ref = (phase == PH_REF);

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    assign cap_en[i] = in_ref ? (cap_idx == CAP_W'(i)) : 1'b1;
  end

  for (genvar j = 0; j < NODES; j++) begin : g_tap
    assign tap_en[j] = in_ref && (node_idx == NODE_W'(j));
  end

  assign brg_en    = (phase == PH_SIG);
  assign gnd_en    = (phase == PH_OFS);
  assign closed    = (stage == ST_RUN);
  assign precharge = in_ref && (node_idx == '0);
  assign rgnd_en   = closed && precharge;
  assign intg_en   = closed && !precharge;

endmodule

// File: rtl/pw_switch_seq.sv
`timescale 1ns/1ps
module pw_switch_seq
  import sps_pkg::*;
#(
  parameter int unsigned NCAP    = 8,
  parameter int unsigned NODES   = 5,
  parameter int unsigned DEAD    = 2,
  parameter int unsigned EXC_DIV = 4,
  localparam int unsigned CAP_W  = $clog2(NCAP),
  localparam int unsigned NODE_W = $clog2(NODES)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_trip,
  output logic [NCAP-1:0]  cap_en,
  output logic [NODES-1:0] tap_en,
  output logic             brg_en,
  output logic             gnd_en,
  output logic             intg_en,
  output logic             rgnd_en,
  output logic             ofs_inj,
  output logic             exc_pol,
  output logic [1:0]       phase_tag
);

  stage_e            stage_w;
  logic              advance_w;
  phase_e            phase_w;
  logic [CAP_W-1:0]  cap_w;
  logic [NODE_W-1:0] node_w;

  sps_stage_timer #(.DEAD(DEAD)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .trip    (cmp_trip),
    .stage   (stage_w),
    .advance (advance_w),
    .inj     (ofs_inj)
  );

  sps_position #(.NCAP(NCAP), .NODES(NODES), .EXC_DIV(EXC_DIV)) u_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance_w),
    .phase_q (phase_w),
    .cap_q   (cap_w),
    .node_q  (node_w),
    .exc_q   (exc_pol)
  );

  sps_switch_map #(.NCAP(NCAP), .NODES(NODES)) u_map (
    .phase    (phase_w),
    .cap_idx  (cap_w),
    .node_idx (node_w),
    .stage    (stage_w),
    .cap_en   (cap_en),
    .tap_en   (tap_en),
    .brg_en   (brg_en),
    .gnd_en   (gnd_en),
    .intg_en  (intg_en),
    .rgnd_en  (rgnd_en)
  );

  assign phase_tag = phase_w;

endmodule

// File: rtl/sps_checker.sv
`timescale 1ns/1ps
module sps_checker #(
  parameter int unsigned NCAP  = 8,
  parameter int unsigned NODES = 5,
  parameter int unsigned DEAD  = 2,
  localparam int unsigned CW   = $clog2(DEAD + 1) + 1,
  localparam int unsigned LW   = NCAP + NODES + 2
)(
  input logic             clk,
  input logic             rst_n,
  input logic             cmp_trip,
  input logic [NCAP-1:0]  cap_en,
  input logic [NODES-1:0] tap_en,
  input logic             brg_en,
  input logic             gnd_en,
  input logic             intg_en,
  input logic             rgnd_en,
  input logic             ofs_inj,
  input logic             exc_pol,
  input logic [1:0]       phase_tag,
  input logic [1:0]       stage_w,
  input logic             advance_w
);

  logic          closed;
  logic [LW-1:0] left;
  logic [LW-1:0] prev_left;
  logic [CW-1:0] open_run;
  logic [CW-1:0] since_left;

  assign closed = intg_en | rgnd_en;
  assign left   = {cap_en, tap_en, brg_en, gnd_en};

  // consecutive open cycles before the current one, saturating at DEAD
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      open_run <= '0;
    else if (closed)                 open_run <= '0;
    else if (open_run < CW'(DEAD))   open_run <= open_run + 1'b1;
  end

  // cycles since the far side last changed, saturating at DEAD
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_left  <= left;
      since_left <= CW'(DEAD);
    end else begin
      prev_left <= left;
      if (left != prev_left)             since_left <= CW'(1);
      else if (since_left < CW'(DEAD))   since_left <= since_left + 1'b1;
    end
  end

  AST_TRIP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(closed) |-> $past(cmp_trip)); // R2
  AST_ADV_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    advance_w |=> (!closed && stage_w == 2'd0)); // R2
  AST_RIGHT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(intg_en && rgnd_en)); // R3
  AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(closed) |-> $stable(left)); // R3
  AST_LEFT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(left) |-> (!closed && open_run >= CW'(DEAD))); // R3
  AST_MAKE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(closed) |-> (since_left >= CW'(DEAD) && $stable(left))); // R3
  AST_SIG_ALLCAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_tag == 2'd0) |-> (&cap_en && brg_en && !rgnd_en)); // R4
  AST_REF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_tag == 2'd1) |-> ($onehot(cap_en) && $onehot(tap_en))); // R5
  AST_OFS_GND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_tag == 2'd2) |-> (gnd_en && &cap_en && !rgnd_en)); // R6
  AST_EXC_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(exc_pol) |-> (!closed && !$past(closed))); // R7
  AST_INJ_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(closed) |-> ofs_inj); // R8
  AST_INJ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_inj |-> (closed && !$past(closed))); // R8
  AST_LEFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0({brg_en, gnd_en, |tap_en}) && $onehot0(tap_en))); // R9

endmodule

bind pw_switch_seq sps_checker #(.NCAP(NCAP), .NODES(NODES), .DEAD(DEAD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_trip  (cmp_trip),
  .cap_en    (cap_en),
  .tap_en    (tap_en),
  .brg_en    (brg_en),
  .gnd_en    (gnd_en),
  .intg_en   (intg_en),
  .rgnd_en   (rgnd_en),
  .ofs_inj   (ofs_inj),
  .exc_pol   (exc_pol),
  .phase_tag (phase_tag),
  .stage_w   (stage_w),
  .advance_w (advance_w)
);

// File: tb/pw_switch_seq_test.sv
`timescale 1ns/1ps
module pw_switch_seq_test;

  localparam int NCAP    = 8;
  localparam int NODES   = 5;
  localparam int DEAD    = 2;
  localparam int EXC_DIV = 4;

  typedef struct {
    int               ph;
    logic [NCAP-1:0]  cap;
    logic [NODES-1:0] tap;
    bit               brg;
    bit               gnd;
    bit               rg;
    bit               tog;
  } step_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_trip = 1'b0;
  logic [NCAP-1:0]  cap_en;
  logic [NODES-1:0] tap_en;
  logic brg_en, gnd_en, intg_en, rgnd_en, ofs_inj, exc_pol;
  logic [1:0] phase_tag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pw_switch_seq #(.NCAP(NCAP), .NODES(NODES), .DEAD(DEAD), .EXC_DIV(EXC_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_trip(cmp_trip),
    .cap_en(cap_en), .tap_en(tap_en), .brg_en(brg_en), .gnd_en(gnd_en),
    .intg_en(intg_en), .rgnd_en(rgnd_en), .ofs_inj(ofs_inj),
    .exc_pol(exc_pol), .phase_tag(phase_tag)
  );

  // schedule of one full pass, built from the requirements
  step_t sched[$];

  initial begin
    step_t s;
    for (int k = 0; k < NCAP * NODES; k++) begin
      s.ph = 0; s.cap = '1; s.tap = '0; s.brg = 1; s.gnd = 0; s.rg = 0; s.tog = 1;
      sched.push_back(s);
    end
    for (int k = 0; k < NCAP * NODES; k++) begin
      s.ph = 1; s.cap = '0; s.cap[k / NODES] = 1'b1;
      s.tap = '0; s.tap[k % NODES] = 1'b1;
      s.brg = 0; s.gnd = 0; s.rg = (k % NODES == 0); s.tog = (k % EXC_DIV == 0);
      sched.push_back(s);
    end
    for (int k = 0; k < NCAP * NODES / 2; k++) begin
      s.ph = 2; s.cap = '1; s.tap = '0; s.brg = 0; s.gnd = 1; s.rg = 0; s.tog = 0;
      sched.push_back(s);
    end
  end

  // behavioural timing model: 0 far-side settling, 1 closed, 2 break
  int pos = 0, mst = 0, mdly = 0, wraps = 0;
  bit mexc = 0, minj = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pos = 0; mst = 0; mdly = 0; mexc = 0; minj = 0;
    end else begin
      minj = 0;
      if (mst == 0) begin
        if (mdly == DEAD - 1) begin mst = 1; mdly = 0; minj = 1; end
        else mdly++;
      end else if (mst == 1) begin
        if (cmp_trip) begin mst = 2; mdly = 0; end
      end else begin
        if (mdly == DEAD - 1) begin
          mst = 0; mdly = 0;
          pos = (pos + 1) % sched.size();
          if (pos == 0) wraps++;
          if (sched[pos].tog) mexc = ~mexc;
        end else mdly++;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    step_t s;
    string tg;
    bit cl;
    s  = sched[pos];
    cl = (mst == 1);
    tg = (s.ph == 0) ? "R4" : (s.ph == 1) ? "R5" : "R6";
    chk(tg, "phase_tag", phase_tag, s.ph);
    chk(tg, "cap_en", cap_en, s.cap);
    chk(tg, "tap_en", tap_en, s.tap);
    chk(tg, "brg_en", brg_en, s.brg);
    chk(tg, "gnd_en", gnd_en, s.gnd);
    chk("R2", "closed", intg_en | rgnd_en, cl);
    chk("R3", "intg_en", intg_en, cl && !s.rg);
    chk("R5", "rgnd_en", rgnd_en, cl && s.rg);
    chk("R7", "exc_pol", exc_pol, mexc);
    chk("R8", "ofs_inj", ofs_inj, minj);
    chk("R9", "far side exclusive", $onehot0({brg_en, gnd_en, |tap_en}), 1);
  endtask

  task automatic run(input int mode, input int cycles);
    logic [15:0] lf = 16'hACE1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (mode)
        0:       cmp_trip = 1'b1;
        1:       cmp_trip = (c % 7 == 3);
        default: cmp_trip = lf[0];
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset phase_tag", phase_tag, 0);
    chk("R1", "reset cap_en", cap_en, {NCAP{1'b1}});
    chk("R1", "reset brg_en", brg_en, 1);
    chk("R1", "reset closed", intg_en | rgnd_en, 0);
    chk("R1", "reset exc_pol", exc_pol, 0);
    rst_n = 1'b1;
    repeat (DEAD - 1) begin
      @(negedge clk);
      chk("R1", "still open", intg_en, 0);
    end
    @(negedge clk);
    chk("R1", "first close", intg_en, 1);
    chk("R1", "first inj", ofs_inj, 1);
    run(0, 1200);
    run(1, 2500);
    run(2, 2500);
    chk("R6", "full passes completed", wraps >= 3, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule